// File: doc/BRIEF.md
# PWM Chopper with Latched Overcurrent Cut-off

This block produces the single drive-allow signal that a motor commutator uses to gate its bridge outputs. An internal sawtooth, an up-counter running from zero to a programmable terminal count, is compared with a speed setpoint. Drive is permitted while the setpoint is below the counter. An external enable, which may itself carry a chopped waveform, is synchronized and ANDed in.

A synchronized overcurrent comparator bit sets a fault latch, and the latch removes drive on the next clock edge. Only a clearing event can release the latch: a rising edge of the enable or the counter wrapping to zero. Even then it releases only if the fault is gone at that moment, so fault retries happen at most at the chopping rate. A brake request masks the overcurrent input.

When chopping is done by the enable alone, the oscillator-hold control parks the counter at its terminal count and the setpoint is tied to zero. The counter must keep running whenever the enable stays high, because the wrap is then the only event that can clear the latch.

Top module: `chop_gate`

## Requirements
- R1: While reset is asserted, and until the first evaluation after its synchronous release, `drive_ok` is 0.
- R2: With `osc_hold` low, the counter steps 0,1,…,`period_max` and then returns to 0. `drive_ok` is 1 in the cycles where `speed_set` is less than the counter value. For `speed_set` < `period_max`, the duty is therefore (`period_max` − `speed_set`) out of every `period_max`+1 cycles when enable is high and no fault is present.
- R3: When `speed_set` ≥ `period_max` and the counter is running, `drive_ok` stays 0.
- R4: With `osc_hold` high, the counter is parked at `period_max` and produces no wrap events. With `speed_set` = 0, `drive_ok` then follows `en_in` alone, delayed by three clock edges: two synchronizer stages and one output register.
- R5: `oc_flag` high at a clock edge while `brake` is low makes `drive_ok` 0 after that same edge.
- R6: Once latched, the fault keeps `drive_ok` at 0 after `oc_flag` falls, for as long as no clearing event occurs.
- R7: A rising edge of the synchronized enable clears the latch when no fault is present. `drive_ok` returns on the third clock edge after `en_in` rises.
- R8: The counter wrapping from `period_max` to 0 clears the latch when no fault is present.
- R9: A clearing event that occurs while `oc_flag` is high leaves the latch set. If set and clear coincide, set wins.
- R10: While `brake` is high, `oc_flag` is ignored: the latch does not set and `drive_ok` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| speed_set | input | CNT_W | Speed setpoint compared against the sawtooth |
| period_max | input | CNT_W | Sawtooth terminal count |
| oc_flag | input | 1 | Synchronized overcurrent comparator bit, 1 = fault |
| en_in | input | 1 | External enable, possibly chopped, asynchronous |
| brake | input | 1 | Brake request, masks the overcurrent input |
| osc_hold | input | 1 | Parks the sawtooth at its terminal count |
| drive_ok | output | 1 | Registered drive-allow |

## Verification
The bench drops the fault before any clearing event occurs and checks that drive stays off. A design that cleared the latch on the fault simply going away would restore drive early. It issues enable edges and counter wraps while the fault is still high; a design that let clear beat set would pulse drive on. It counts high cycles over whole sawtooth periods at a setpoint of zero, in the middle of the range, and at or above the terminal count. Those counts expose an inverted or off-by-one comparison, or a wrong wrap point. It also holds a fault during brake, where a latch that ignored the mask would cut drive.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic [1:0] {
    LAT_KEEP = 2'd0,
    LAT_SET  = 2'd1,
    LAT_CLR  = 2'd2
  } lat_op_e;
endpackage

// File: rtl/chop_saw.sv
module chop_saw #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [CNT_W-1:0] top_cnt,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q >= top_cnt);
    wrap   = !hold && at_top;
    if (hold)        cnt_d = top_cnt;
    else if (at_top) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R8
  AST_HOLD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !wrap); // R4
endmodule

// File: rtl/chop_en_sync.sv
module chop_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_raw,
  output logic en_s,
  output logic en_rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d    = {sh_q[LAST:0], en_raw};
    en_s    = sh_q[LAST];
    en_rise = sh_q[LAST] & ~sh_q[STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> !en_rise); // R7
endmodule

// File: rtl/chop_oc_latch.sv
module chop_oc_latch
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic brake,
  input  logic clr_evt,
  output logic lat_q,
  output logic lat_d
);
  lat_op_e op;
  logic    q;

  always_comb begin
    if (fault && !brake)        op = LAT_SET;
    else if (clr_evt && !fault) op = LAT_CLR;
    else                        op = LAT_KEEP;
    case (op)
      LAT_SET: lat_d = 1'b1;
      LAT_CLR: lat_d = 1'b0;
      default: lat_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= lat_d;
  end

  assign lat_q = q;

  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !brake) |=> lat_q); // R5
  AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr_evt) |=> lat_q); // R6
  AST_FAULT_BLOCKS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && fault) |=> lat_q); // R9
  AST_BRAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (brake && !lat_q && !clr_evt) |=> !lat_q); // R10
endmodule

// File: rtl/chop_gate.sv
module chop_gate
  import chop_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] speed_set,
  input  logic [CNT_W-1:0] period_max,
  input  logic             oc_flag,
  input  logic             en_in,
  input  logic             brake,
  input  logic             osc_hold,
  output logic             drive_ok
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  logic             wrap, en_s, en_rise, clr_evt;
  logic             lat_q, lat_d, pwm_on, drive_d, drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  chop_saw #(.CNT_W(CNT_W)) saw_i (
    .clk(clk), .rst_n(rst_sync_n), .hold(osc_hold),
    .top_cnt(period_max), .cnt(cnt), .wrap(wrap)
  );

  chop_en_sync #(.STAGES(STAGES)) ens_i (
    .clk(clk), .rst_n(rst_sync_n), .en_raw(en_in),
    .en_s(en_s), .en_rise(en_rise)
  );

  always_comb begin
    clr_evt = en_rise | wrap;
    pwm_on  = (speed_set < cnt);
    drive_d = en_s & pwm_on & ~lat_d;
  end

  chop_oc_latch lat_i (
    .clk(clk), .rst_n(rst_sync_n), .fault(oc_flag), .brake(brake),
    .clr_evt(clr_evt), .lat_q(lat_q), .lat_d(lat_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) drive_q <= 1'b0;
    else             drive_q <= drive_d;
  end

  assign drive_ok = drive_q;

  AST_FAULT_CUTS_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_flag && !brake) |=> !drive_ok); // R5
  AST_DRIVE_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drive_ok |-> !lat_q); // R6
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_sync_n |-> !drive_ok); // R1
endmodule

// File: tb/chop_gate_tb_top.sv
module chop_gate_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int P     = 9;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] speed_set, period_max;
  logic         oc_flag, en_in, brake, osc_hold;
  logic         drive_ok;

  typedef struct { string tag; int val; } exp_t;
  exp_t exp_q[$];
  int   obs_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  always #(CLK_P/2) clk = ~clk;

  chop_gate #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .speed_set(speed_set), .period_max(period_max),
    .oc_flag(oc_flag), .en_in(en_in), .brake(brake), .osc_hold(osc_hold),
    .drive_ok(drive_ok)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(string tag, int val);
    exp_t e;
    e.tag = tag; e.val = val;
    exp_q.push_back(e);
  endtask

  task automatic observe(int val);
    obs_q.push_back(val);
  endtask

  task automatic check_now(string tag, int val);
    expect_item(tag, val);
    observe(int'(drive_ok));
  endtask

  task automatic count_high(string tag, int n, int val);
    int c = 0;
    expect_item(tag, val);
    for (int i = 0; i < n; i++) begin
      step(1);
      c += int'(drive_ok);
    end
    observe(c);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      exp_t e;
      int   o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      checks++;
      if (o != e.val) begin
        errors++;
        $display("FAIL %s actual=%0d expected=%0d", e.tag, o, e.val);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      if (exp_q.size() != 0 || obs_q.size() != 0) begin
        errors++;
        $display("FAIL scoreboard actual=%0d expected=%0d", obs_q.size(), exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; speed_set = '0; period_max = W'(P);
    oc_flag = 1'b0; en_in = 1'b1; brake = 1'b0; osc_hold = 1'b1;
    step(3);
    check_now("R1 drive during reset", 0);
    rst_n = 1'b1;
    step(1);
    check_now("R1 drive right after release", 0);
    step(10);

    // R4: hold mode, enable-only chopping, three-edge latency
    check_now("R4 hold mode drive on", 1);
    en_in = 1'b0; step(2);
    check_now("R4 enable fall not yet seen", 1);
    step(1);
    check_now("R4 enable fall after three edges", 0);
    en_in = 1'b1; step(2);
    check_now("R4 enable rise not yet seen", 0);
    step(1);
    check_now("R4 enable rise after three edges", 1);

    // R5 / R6
    oc_flag = 1'b1; step(1);
    check_now("R5 fault cuts drive next edge", 0);
    oc_flag = 1'b0; step(1);
    check_now("R6 latched after fault drops", 0);
    step(20);
    check_now("R6 still latched without clear", 0);

    // R7: enable edge clears
    en_in = 1'b0; step(5);
    en_in = 1'b1; step(2);
    check_now("R7 before clear edge", 0);
    step(1);
    check_now("R7 drive back after enable rise", 1);

    // R9: clear while fault present
    oc_flag = 1'b1; step(1);
    check_now("R5 second fault", 0);
    en_in = 1'b0; step(5);
    en_in = 1'b1; step(5);
    check_now("R9 enable edge during fault", 0);
    oc_flag = 1'b0; step(10);
    check_now("R9 latch kept after fault gone", 0);
    en_in = 1'b0; step(5);
    en_in = 1'b1; step(3);
    check_now("R7 clear after fault gone", 1);

    // R10: brake masks fault
    brake = 1'b1; oc_flag = 1'b1; step(5);
    check_now("R10 fault ignored under brake", 1);
    oc_flag = 1'b0; step(1);
    brake = 1'b0; step(3);
    check_now("R10 no latch left after brake", 1);

    // R2 / R3: running sawtooth
    osc_hold = 1'b0; speed_set = W'(3); step(P + 3);
    count_high("R2 duty at setpoint 3", 100, 10 * (P - 3));
    speed_set = '0; step(2);
    count_high("R2 duty at setpoint 0", 100, 10 * P);
    speed_set = W'(P); step(2);
    count_high("R3 setpoint at terminal count", 100, 0);
    speed_set = W'(200); step(2);
    count_high("R3 setpoint above terminal count", 100, 0);

    // R8: wrap clears, enable held high
    speed_set = '0; step(2);
    oc_flag = 1'b1; step(1);
    check_now("R5 fault with sawtooth running", 0);
    oc_flag = 1'b0; step(P + 3);
    count_high("R8 wrap cleared latch", 100, 10 * P);
    oc_flag = 1'b1; step(1);
    count_high("R9 wraps during held fault", 30, 0);
    oc_flag = 1'b0;

    step(4);
    finish_run();
  end
endmodule